// File: doc/BRIEF.md
# Multiplexed BCD Reading Display Demultiplexer

This block sits at the receiving end of a time-multiplexed 3½-digit BCD bus. Four digit-select strobes arrive in turn. The first strobe carries a status nibble. The next three carry the hundreds, tens and units digits. While a strobe is high, the block stores the 4-bit bus value in the register for that slot. When the units strobe ends, it moves all four stored values to the display at the same moment. A reading that has only been partly received therefore never reaches the segments.

The status nibble is decoded into three things. The first is the leading half digit, which is either a lit "1" or dark. The second is the sign, driven on separate plus and minus outputs. The third is the range condition. Each of the three full digits passes through a seven-segment decoder that shows decimal codes and darkens every code above nine. When the committed reading is overrange, the display is hidden: the segment outputs and both sign outputs go low. In flash mode it is hidden on alternate windows, and each window is a fixed number of end-of-conversion pulses long. In blank mode it stays hidden for as long as the reading is overrange.

Top module: `bcd_display_demux`

## Requirements
- R1: While `digitSel[k]` is high at a clock edge, the bus value is stored in slot k. Slot 0 is the status, 1 is hundreds, 2 is tens and 3 is units. A slot keeps its value while its strobe is low.
- R2: All four stored values move to the display at the first clock edge where `digitSel[3]` is low after it was high at the edge before. The outputs do not change at any other edge.
- R3: Each full digit drives a 7-bit active-high segment vector, with bit 0 = a through bit 6 = g. The codes 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hexadecimal).
- R4: Digit codes 10 to 15 drive all seven segments of that digit low.
- R5: When status bit 3 is 0, the half digit lights segments b and c (`7'b0000110`). When status bit 3 is 1, the half digit is dark.
- R6: When status bit 2 is 1, `signPlus` is high and `signMinus` is low. When status bit 2 is 0, the opposite holds. The two are never high together.
- R7: Overrange means status bit 0 = 1 and bit 3 = 0. Underrange means status bit 0 = 1 and bit 3 = 1. An underrange reading is displayed normally.
- R8: With `blankMode` low, an overrange reading starts out visible. Visibility then toggles after every FLASH_CONV (default 2) rising edges of `eoc`. While hidden, all segment outputs and both sign outputs are low.
- R9: With `blankMode` high, an overrange reading keeps all segment outputs and both sign outputs low.
- R10: After reset the display holds status `4'b1100` and digit codes `4'hF`. So only `signPlus` is high and every segment output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bcdBus | input | 4 | Multiplexed BCD / status nibble |
| digitSel | input | 4 | Slot strobes: 0 status, 1 hundreds, 2 tens, 3 units |
| eoc | input | 1 | End-of-conversion pulse |
| blankMode | input | 1 | 1 = blank on overrange, 0 = flash |
| segHalf | output | 7 | Half-digit segments a..g |
| segHund | output | 7 | Hundreds segments a..g |
| segTens | output | 7 | Tens segments a..g |
| segUnits | output | 7 | Units segments a..g |
| signPlus | output | 1 | Plus sign drive |
| signMinus | output | 1 | Minus sign drive |

## Verification
A wrong value in a stored slot is not visible right away. It appears only on the edge that follows the fall of the units strobe, and from then on it stays wrong on every cycle until the next commit. A commit that comes too early shows up in the middle of a frame: some digits take on the new values while the units digit still shows the old one. A fault in the flash counter appears at the first `eoc` rising edge where the window should have toggled. The reference model in the bench updates on every clock edge, so every one of these faults is found in the cycle where it first affects the outputs.

// File: rtl/bcd_disp_pkg.sv
package bcd_disp_pkg;
  localparam int SLOTS   = 4;
  localparam int NIB_W   = 4;
  localparam int SEG_W   = 7;

  typedef struct packed {
    logic [SLOTS-1:0] capEn;
    logic             commit;
  } dispCtrl_t;

  localparam logic [SEG_W-1:0] HALF_SEGS  = 7'b0000110;
  localparam logic [NIB_W-1:0] STATUS_RST = 4'b1100;
  localparam logic [NIB_W-1:0] DIGIT_RST  = 4'hF;
endpackage

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_disp_pkg::*;
(
  input  logic [NIB_W-1:0] code,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    unique case (code)
      4'd0: seg = 7'h3F;
      4'd1: seg = 7'h06;
      4'd2: seg = 7'h5B;
      4'd3: seg = 7'h4F;
      4'd4: seg = 7'h66;
      4'd5: seg = 7'h6D;
      4'd6: seg = 7'h7D;
      4'd7: seg = 7'h07;
      4'd8: seg = 7'h7F;
      4'd9: seg = 7'h6F;
      default: seg = '0;
    endcase
  end
endmodule

// File: rtl/bcd_disp_ctrl.sv
module bcd_disp_ctrl
  import bcd_disp_pkg::*;
#(
  parameter int FLASH_CONV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] digitSel,
  input  logic             eoc,
  input  logic             blankMode,
  input  logic             overRange,
  output dispCtrl_t        ctrl,
  output logic             hide
);
  localparam int CNT_W = $clog2(FLASH_CONV + 1);

  logic             unitsPrev;
  logic             eocPrev;
  logic             eocRise;
  logic             visible;
  logic [CNT_W-1:0] flashCnt;

  assign eocRise     = eoc & ~eocPrev;
  assign ctrl.capEn  = digitSel;
  assign ctrl.commit = unitsPrev & ~digitSel[SLOTS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitsPrev <= 1'b0;
      eocPrev   <= 1'b0;
    end else begin
      unitsPrev <= digitSel[SLOTS-1];
      eocPrev   <= eoc;
    end
  end

  // flash window: counts conversions while the reading is overrange
  always_ff @(posedge clk) begin
    if (!rstN || !overRange) begin
      flashCnt <= '0;
      visible  <= 1'b1;
    end else if (eocRise) begin
      if (flashCnt == CNT_W'(FLASH_CONV - 1)) begin
        flashCnt <= '0;
        visible  <= ~visible;
      end else begin
        flashCnt <= flashCnt + 1'b1;
      end
    end
  end

  assign hide = overRange & (blankMode | ~visible);

  p_hide_needs_over_r8: assert property (@(posedge clk) disable iff (!rstN)
    hide |-> overRange);
  p_blank_hides_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overRange && blankMode) |-> hide);
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    flashCnt < CNT_W'(FLASH_CONV));
  p_quiet_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overRange && !eocRise) |=> (!overRange || $stable(visible)));
endmodule

// File: rtl/bcd_disp_datapath.sv
module bcd_disp_datapath
  import bcd_disp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] bcdBus,
  input  dispCtrl_t        ctrl,
  input  logic             hide,
  output logic             overRange,
  output logic [SEG_W-1:0] segHalf,
  output logic [SEG_W-1:0] segHund,
  output logic [SEG_W-1:0] segTens,
  output logic [SEG_W-1:0] segUnits,
  output logic             signPlus,
  output logic             signMinus
);
  logic [NIB_W-1:0] capReg   [SLOTS];
  logic [NIB_W-1:0] shownReg [SLOTS];
  logic [SEG_W-1:0] segRaw   [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [NIB_W-1:0] RST_V = (s == 0) ? STATUS_RST : DIGIT_RST;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capReg[s]   <= RST_V;
        shownReg[s] <= RST_V;
      end else begin
        if (ctrl.commit)   shownReg[s] <= capReg[s];
        if (ctrl.capEn[s]) capReg[s]   <= bcdBus;
      end
    end

    if (s == 0) begin : g_status
      assign segRaw[s] = shownReg[s][3] ? '0 : HALF_SEGS;
    end else begin : g_digit
      bcd_seg_decoder u_dec (.code(shownReg[s]), .seg(segRaw[s]));
    end

    p_cap_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.capEn[s] |=> $stable(capReg[s]));
    p_commit_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.commit |=> shownReg[s] == $past(capReg[s]));
    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.commit |=> $stable(shownReg[s]));
  end

  logic statusPos;
  assign statusPos = shownReg[0][2];
  assign overRange = shownReg[0][0] & ~shownReg[0][3];

  assign segHalf   = hide ? '0 : segRaw[0];
  assign segHund   = hide ? '0 : segRaw[1];
  assign segTens   = hide ? '0 : segRaw[2];
  assign segUnits  = hide ? '0 : segRaw[3];
  assign signPlus  = ~hide & statusPos;
  assign signMinus = ~hide & ~statusPos;

  p_sign_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(signPlus && signMinus));
  p_half_shape_r5: assert property (@(posedge clk) disable iff (!rstN)
    (segHalf == '0) || (segHalf == HALF_SEGS));
  p_nondec_dark_r4: assert property (@(posedge clk) disable iff (!rstN)
    (shownReg[3] > 4'd9) |-> (segUnits == '0));
endmodule

// File: rtl/bcd_display_demux.sv
module bcd_display_demux
  import bcd_disp_pkg::*;
#(
  parameter int FLASH_CONV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] bcdBus,
  input  logic [3:0] digitSel,
  input  logic       eoc,
  input  logic       blankMode,
  output logic [6:0] segHalf,
  output logic [6:0] segHund,
  output logic [6:0] segTens,
  output logic [6:0] segUnits,
  output logic       signPlus,
  output logic       signMinus
);
  dispCtrl_t ctrl;
  logic      hide;
  logic      overRange;

  bcd_disp_ctrl #(.FLASH_CONV(FLASH_CONV)) u_ctrl (
    .clk(clk), .rstN(rstN), .digitSel(digitSel), .eoc(eoc),
    .blankMode(blankMode), .overRange(overRange), .ctrl(ctrl), .hide(hide)
  );

  bcd_disp_datapath u_dp (
    .clk(clk), .rstN(rstN), .bcdBus(bcdBus), .ctrl(ctrl), .hide(hide),
    .overRange(overRange), .segHalf(segHalf), .segHund(segHund),
    .segTens(segTens), .segUnits(segUnits), .signPlus(signPlus),
    .signMinus(signMinus)
  );
endmodule

// File: tb/bcd_display_demux_bench.sv
module bcd_display_demux_bench;
  localparam int FLASH = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] bcdBus = 4'h0;
  logic [3:0] digitSel = 4'h0;
  logic       eoc = 1'b0;
  logic       blankMode = 1'b0;
  logic [6:0] segHalf, segHund, segTens, segUnits;
  logic       signPlus, signMinus;

  int    nCmp = 0;
  int    nBad = 0;
  string curReq = "R10";
  bit    done = 0;

  always #2.5 clk = ~clk;

  bcd_display_demux #(.FLASH_CONV(FLASH)) u_bcd_display_demux (
    .clk(clk), .rstN(rstN), .bcdBus(bcdBus), .digitSel(digitSel), .eoc(eoc),
    .blankMode(blankMode), .segHalf(segHalf), .segHund(segHund),
    .segTens(segTens), .segUnits(segUnits), .signPlus(signPlus),
    .signMinus(signMinus)
  );

  // behavioural reference model
  int mCap[4];
  int mShow[4];
  bit mPrevUnits, mPrevEoc, mVis;
  int mCnt;

  function automatic bit mOver();
    return ((mShow[0] & 1) != 0) && ((mShow[0] & 8) == 0);
  endfunction

  function automatic logic [6:0] digitPattern(int v);
    logic [6:0] tbl[10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                            7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    if (v >= 0 && v <= 9) return tbl[v];
    return 7'h00;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCap = '{12, 15, 15, 15};
      mShow = '{12, 15, 15, 15};
      mPrevUnits = 0; mPrevEoc = 0; mVis = 1; mCnt = 0;
    end else begin
      if (!mOver()) begin
        mCnt = 0; mVis = 1;
      end else if (eoc && !mPrevEoc) begin
        mCnt++;
        if (mCnt == FLASH) begin mCnt = 0; mVis = !mVis; end
      end
      if (mPrevUnits && !digitSel[3])
        for (int i = 0; i < 4; i++) mShow[i] = mCap[i];
      for (int i = 0; i < 4; i++) if (digitSel[i]) mCap[i] = int'(bcdBus);
      mPrevUnits = digitSel[3];
      mPrevEoc = eoc;
    end
  end

  task automatic cmp(string what, logic [6:0] act, logic [6:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      bit hid;
      hid = mOver() && (blankMode || !mVis);
      cmp("segHalf",  segHalf,  hid ? 7'h00 : (((mShow[0] & 8) == 0) ? 7'b0000110 : 7'h00));
      cmp("segHund",  segHund,  hid ? 7'h00 : digitPattern(mShow[1]));
      cmp("segTens",  segTens,  hid ? 7'h00 : digitPattern(mShow[2]));
      cmp("segUnits", segUnits, hid ? 7'h00 : digitPattern(mShow[3]));
      cmp("signPlus",  {6'b0, signPlus},  {6'b0, !hid && ((mShow[0] & 4) != 0)});
      cmp("signMinus", {6'b0, signMinus}, {6'b0, !hid && ((mShow[0] & 4) == 0)});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendReading(logic [3:0] st, logic [3:0] h, logic [3:0] t, logic [3:0] u);
    logic [3:0] v[4];
    v = '{st, h, t, u};
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      digitSel = 4'(1 << s);
      bcdBus = v[s];
      idle(3);
      digitSel = 4'h0;
      bcdBus = 4'hA;
      idle(1);
    end
    idle(3);
  endtask

  task automatic pulseEoc(int gap);
    @(negedge clk); eoc = 1'b1;
    @(negedge clk); eoc = 1'b0;
    idle(gap);
  endtask

  task automatic finishUp();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #200000;
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    finishUp();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    curReq = "R10"; idle(4);            // reset state: plus only
    curReq = "R1";  sendReading(4'b0100, 4'd1, 4'd2, 4'd3);
    curReq = "R2";  sendReading(4'b0000, 4'd4, 4'd5, 4'd6);  // mid-frame holds old
    curReq = "R3";
    sendReading(4'b1100, 4'd7, 4'd8, 4'd9);
    sendReading(4'b1000, 4'd0, 4'd0, 4'd0);
    curReq = "R4";
    sendReading(4'b0100, 4'd10, 4'd11, 4'd12);
    sendReading(4'b0100, 4'd13, 4'd14, 4'd15);
    curReq = "R5";  sendReading(4'b0100, 4'd9, 4'd9, 4'd9);
    curReq = "R6";  sendReading(4'b1000, 4'd3, 4'd1, 4'd4);
    curReq = "R7";  sendReading(4'b1101, 4'd1, 4'd7, 4'd0);   // underrange shown
    for (int i = 0; i < 3; i++) pulseEoc(2);
    curReq = "R8";  blankMode = 1'b0;
    sendReading(4'b0101, 4'd9, 4'd9, 4'd9);
    for (int i = 0; i < 7; i++) pulseEoc(3);
    curReq = "R9";  blankMode = 1'b1;
    idle(3);
    for (int i = 0; i < 3; i++) pulseEoc(2);
    blankMode = 1'b0; idle(2);
    curReq = "R7";  sendReading(4'b0100, 4'd2, 4'd0, 4'd1);   // back in range
    pulseEoc(2);
    idle(4);
    finishUp();
  end
endmodule